// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is the byte-wide register front end of a real-time clock. Software reaches it through two ports. The index port selects one of 128 internal locations. The data port then reads or writes the selected location. Behind the ports sit four status registers, three alarm bytes, a 114-byte general-purpose non-volatile store, and a read-only view of the time of day.

The time of day comes from an external calendar. That calendar supplies binary fields at one-second resolution and raises a tick each second. The block keeps a snapshot of these fields. It refreshes the snapshot at most once per tick, and only on a data-port access while the halt bit is clear. Successive reads of hours, minutes and seconds therefore stay coherent.

Each request gets a registered response one cycle later. The response carries the read byte and an error strobe. The error strobe marks a rejected access, and a rejected access changes no state.

Top module: `rtc_regfile`

## Requirements
- R1: A request whose size (`req_bytes`) is not 1 is rejected with `rsp_err`. It changes neither the selected index nor any register.
- R2: A byte read of the index port (`req_port`=0) returns 0xFF with no error. On a byte write of the index port, bit 7 is ignored and bits 6:0 become the selected location. All 128 locations are accepted.
- R3: Each request accepted on a clock edge gives `rsp_valid` high for exactly the following cycle. `rsp_err` is high only together with `rsp_valid`. `rsp_rdata` is 0x00 for writes and for rejected accesses.
- R4: A snapshot refresh is pending after reset and after every `sec_tick`. A byte data-port access with a refresh pending and halt clear loads the snapshot from the calendar inputs and clears the pending refresh. A read in that same access already returns the new value. Without a pending refresh, reads keep returning the old snapshot.
- R5: While status B bit 7 (halt) is set, the snapshot does not change. A pending refresh waits until an access that finds halt clear.
- R6: A write to status A (0x0A) stores the byte with bit 7 forced to 0. Status A resets to 0x00.
- R7: A status B (0x0B) write with bit 6 set is rejected with `rsp_err`, and the register is unchanged. Any other value is stored as written. Status B resets to 0x00.
- R8: Status C (0x0C) reads 0x00, and a write to it is rejected. Status D (0x0D) reads 0x80, and a write to it is ignored without error.
- R9: Writes to the time registers (0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 day, 0x08 month, 0x09 year) complete without error and change nothing that can be read.
- R10: The alarm bytes at 0x01, 0x03 and 0x05 store and return raw bytes with no conversion. They reset to 0x00.
- R11: Locations 0x0E to 0x7F are a byte store. They reset to 0x00, except 0x32, which resets to the BCD form of `tod_cent`.
- R12: Time reads use status B bit 2 to choose the format. With bit 2 set they are binary; with it clear they are BCD. Weekday reads as input+1 and month as input+1. With status B bit 1 set, hours read as 0 to 23. With bit 1 clear they read as 1 to 12, and bit 7 is set for hours 12 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 1 | 0 = index port, 1 = data port |
| req_bytes | input | 3 | Access size in bytes; only 1 is accepted |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 8 | Read byte |
| sec_tick | input | 1 | One-cycle pulse once per second |
| tod_sec | input | 6 | Calendar seconds, 0-59 |
| tod_min | input | 6 | Calendar minutes, 0-59 |
| tod_hour | input | 5 | Calendar hour, 0-23 |
| tod_wday | input | 3 | Weekday, 0-6 |
| tod_mday | input | 5 | Day of month, 1-31 |
| tod_mon | input | 4 | Month, 0-11 |
| tod_year | input | 7 | Year within century, 0-99 |
| tod_cent | input | 7 | Century number, sampled at reset |

## Verification
The calendar inputs are changed between reads both with and without a tick in between. This separates a refresh that follows the pending flag from one that follows every access or never happens. The hour read is tried with afternoon values under all four combinations of the 24-hour and binary bits, which shows up a wrong PM flag, a wrong 12-hour fold or BCD applied in the wrong mode. Rejected accesses are each followed by a read of the location they could have touched. These include a wrong size on either port, a status B value with bit 6 set, and a status C write. Halt is set across a tick and then cleared, showing that the refresh waits rather than being lost.

// File: rtl/rtc_regfile_pkg.sv
// Package: shared types and helpers of the indexed clock register file.
// Assumes calendar values below 100 whenever BCD conversion is applied.
package rtc_regfile_pkg;

    localparam int IDX_W  = 7;
    localparam int BYTE_W = 8;

    // Control bit positions in status A / status B
    localparam int SA_UIP  = 7;
    localparam int SB_HALT = 7;
    localparam int SB_PIE  = 6;
    localparam int SB_BIN  = 2;
    localparam int SB_24H  = 1;

    typedef enum logic [2:0] {
        RC_TIME, RC_ALARM, RC_STA, RC_STB, RC_STC, RC_STD, RC_NVRAM
    } reg_class_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [6:0] wday;
        logic [6:0] mday;
        logic [6:0] mon;
        logic [6:0] year;
    } tod_t;

    // Binary to packed BCD for values 0..99
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Presentation according to the binary-mode bit
    function automatic logic [7:0] fmt(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    // Class of a location by its index
    function automatic reg_class_e classify(input logic [IDX_W-1:0] idx);
        case (idx)
            7'h00, 7'h02, 7'h04, 7'h06, 7'h07, 7'h08, 7'h09: return RC_TIME;
            7'h01, 7'h03, 7'h05: return RC_ALARM;
            7'h0A: return RC_STA;
            7'h0B: return RC_STB;
            7'h0C: return RC_STC;
            7'h0D: return RC_STD;
            default: return RC_NVRAM;
        endcase
    endfunction

endpackage

// File: rtl/rtc_access_decode.sv
// Module: rtc_access_decode
// Classifies one request. It checks the size, picks the port and decides
// whether the data-port write rule for the selected class rejects it.
// Purely combinational; assumes cur_idx is the currently selected location.
module rtc_access_decode
    import rtc_regfile_pkg::*;
(
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             req_port_i,
    input  logic [2:0]       req_bytes_i,
    input  logic             wdata_pie_i,
    input  logic [IDX_W-1:0] cur_idx_i,
    output reg_class_e       cls_o,
    output logic             idx_wr_o,
    output logic             data_acc_o,
    output logic             data_wr_o,
    output logic             reject_o
);

    logic size_ok;
    logic rule_reject;

    // Size gate and class lookup
    always_comb begin
        size_ok = (req_bytes_i == 3'd1);
        cls_o   = classify(cur_idx_i);
    end

    // Per-class write rule: status C refuses writes, status B refuses PIE
    always_comb begin
        rule_reject = req_port_i && req_write_i &&
                      ((cls_o == RC_STC) || (cls_o == RC_STB && wdata_pie_i));
        reject_o    = req_valid_i && (!size_ok || rule_reject);
        idx_wr_o    = req_valid_i && size_ok && !req_port_i && req_write_i;
        data_acc_o  = req_valid_i && size_ok && req_port_i;
        data_wr_o   = data_acc_o && req_write_i && !rule_reject;
    end

endmodule

// File: rtl/rtc_tod_snapshot.sv
// Module: rtc_tod_snapshot
// Holds the time-of-day snapshot. A tick arms a refresh. The next accepted
// data-port access with halt clear loads the calendar fields. view_o already
// shows the fresh fields during the access that performs the refresh.
module rtc_tod_snapshot
    import rtc_regfile_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic access_i,
    input  logic halt_i,
    input  tod_t tod_i,
    output tod_t view_o
);

    tod_t snap_q;
    logic pend_q;
    logic do_refresh;

    // Refresh decision for this cycle
    always_comb begin
        do_refresh = access_i && pend_q && !halt_i;
        view_o     = do_refresh ? tod_i : snap_q;
    end

    // Snapshot register and pending flag; reset arms the first refresh
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            pend_q <= 1'b1;
        end else begin
            if (do_refresh) snap_q <= tod_i;
            if (tick_i)          pend_q <= 1'b1;
            else if (do_refresh) pend_q <= 1'b0;
        end
    end

    // R5: halt freezes the snapshot
    p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(snap_q));

    // R4: no pending refresh, no snapshot change
    p_no_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> $stable(snap_q));

    // R4: an access that refreshes clears the pending flag unless a tick arrives
    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && pend_q && !halt_i && !tick_i) |=> !pend_q);

endmodule

// File: rtl/rtc_nvram.sv
// Module: rtc_nvram
// General-purpose byte store for the upper locations. Entry k holds location
// BASE+k. All entries clear at reset, except the century entry, which loads
// cent_bcd_i. Assumes idx_i >= BASE whenever we_i is high.
module rtc_nvram
    import rtc_regfile_pkg::*;
#(
    parameter int BASE     = 14,
    parameter int DEPTH    = 114,
    parameter int CENT_IDX = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] cent_bcd_i,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int OFF_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [OFF_W-1:0]  off;

    // Offset of the selected location inside the store
    always_comb begin
        off     = OFF_W'(idx_i - IDX_W'(BASE));
        rdata_o = (int'(off) < DEPTH) ? mem[off] : '0;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_cell
        localparam bit IS_CENT = ((k + BASE) == CENT_IDX);
        // One storage byte with its own reset value
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[k] <= IS_CENT ? cent_bcd_i : '0;
            else if (we_i && off == OFF_W'(k))
                mem[k] <= wdata_i;
        end
    end

endmodule

// File: rtl/rtc_regfile.sv
// Module: rtc_regfile (top)
// Index/data byte interface of a real-time clock. It holds the selected
// index, status A/B, the alarm bytes and the byte store, and it formats the
// time snapshot on reads. It answers each request one cycle later.
// Assumes a one-cycle sec_tick pulse and calendar fields in range.
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int NV_BASE  = 14,
    parameter int NV_TOP   = 127,
    parameter int CENT_IDX = 50,
    parameter int N_ALARM  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_port,
    input  logic [2:0] req_bytes,
    input  logic [7:0] req_wdata,
    output logic       rsp_valid,
    output logic       rsp_err,
    output logic [7:0] rsp_rdata,
    input  logic       sec_tick,
    input  logic [5:0] tod_sec,
    input  logic [5:0] tod_min,
    input  logic [4:0] tod_hour,
    input  logic [2:0] tod_wday,
    input  logic [4:0] tod_mday,
    input  logic [3:0] tod_mon,
    input  logic [6:0] tod_year,
    input  logic [6:0] tod_cent
);

    localparam int NV_DEPTH = NV_TOP - NV_BASE + 1;

    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] sta_q, stb_q;
    logic [BYTE_W-1:0] alarm_q [N_ALARM];
    logic [BYTE_W-1:0] nv_rdata, rd_val;
    reg_class_e        cls;
    logic              idx_wr, data_acc, data_wr, reject;
    tod_t              tod_in, view;
    logic [6:0]        hr12;

    rtc_access_decode u_decode (
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_port_i  (req_port),
        .req_bytes_i (req_bytes),
        .wdata_pie_i (req_wdata[SB_PIE]),
        .cur_idx_i   (idx_q),
        .cls_o       (cls),
        .idx_wr_o    (idx_wr),
        .data_acc_o  (data_acc),
        .data_wr_o   (data_wr),
        .reject_o    (reject)
    );

    // Widen calendar inputs into the common field layout
    always_comb begin
        tod_in = '{sec:  {1'b0, tod_sec},  min: {1'b0, tod_min},
                   hour: {2'b0, tod_hour}, wday: {4'b0, tod_wday},
                   mday: {2'b0, tod_mday}, mon: {3'b0, tod_mon},
                   year: tod_year};
    end

    rtc_tod_snapshot u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (sec_tick),
        .access_i (data_acc),
        .halt_i   (stb_q[SB_HALT]),
        .tod_i    (tod_in),
        .view_o   (view)
    );

    rtc_nvram #(.BASE(NV_BASE), .DEPTH(NV_DEPTH), .CENT_IDX(CENT_IDX)) u_nvram (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (data_wr && cls == RC_NVRAM),
        .idx_i      (idx_q),
        .wdata_i    (req_wdata),
        .cent_bcd_i (to_bcd(tod_cent)),
        .rdata_o    (nv_rdata)
    );

    // Index register: bit 7 of the written byte is dropped
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= req_wdata[IDX_W-1:0];
    end

    // Status A keeps UIP clear; status B stores what the decoder let through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q <= '0;
            stb_q <= '0;
        end else if (data_wr) begin
            if (cls == RC_STA) sta_q <= req_wdata & ~(8'(1) << SA_UIP);
            if (cls == RC_STB) stb_q <= req_wdata;
        end
    end

    for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
        // Raw alarm byte at odd location 2a+1
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[a] <= '0;
            else if (data_wr && cls == RC_ALARM && idx_q == IDX_W'(2 * a + 1))
                alarm_q[a] <= req_wdata;
        end
    end

    // 12-hour fold of the snapshot hour
    always_comb begin
        if (view.hour == 7'd0)       hr12 = 7'd12;
        else if (view.hour > 7'd12)  hr12 = view.hour - 7'd12;
        else                         hr12 = view.hour;
    end

    // Read multiplexer for the data port
    always_comb begin
        rd_val = '0;
        case (cls)
            RC_TIME: begin
                case (idx_q)
                    7'h00: rd_val = fmt(view.sec, stb_q[SB_BIN]);
                    7'h02: rd_val = fmt(view.min, stb_q[SB_BIN]);
                    7'h04: rd_val = stb_q[SB_24H] ? fmt(view.hour, stb_q[SB_BIN])
                                  : (fmt(hr12, stb_q[SB_BIN]) |
                                     {view.hour >= 7'd12, 7'b0});
                    7'h06: rd_val = fmt(view.wday + 7'd1, stb_q[SB_BIN]);
                    7'h07: rd_val = fmt(view.mday, stb_q[SB_BIN]);
                    7'h08: rd_val = fmt(view.mon + 7'd1, stb_q[SB_BIN]);
                    default: rd_val = fmt(view.year, stb_q[SB_BIN]);
                endcase
            end
            RC_ALARM: rd_val = alarm_q[idx_q[2:1]];
            RC_STA:   rd_val = sta_q;
            RC_STB:   rd_val = stb_q;
            RC_STC:   rd_val = 8'h00;
            RC_STD:   rd_val = 8'h80;
            default:  rd_val = nv_rdata;
        endcase
    end

    // Registered response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= reject;
            if (req_valid && !req_write && !reject)
                rsp_rdata <= req_port ? rd_val : 8'hFF;
            else
                rsp_rdata <= '0;
        end
    end

    // R1: a wrong size always errors
    p_bad_size_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bytes != 3'd1) |=> rsp_err);

    // R1: a wrong size never moves the index
    p_bad_size_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bytes != 3'd1) |=> $stable(idx_q));

    // R2: index-port read returns all ones
    p_index_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_port && req_bytes == 3'd1)
        |=> (rsp_rdata == 8'hFF && !rsp_err));

    // R3: error only travels with a response
    p_err_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R6: status A never holds UIP
    p_sta_uip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sta_q[SA_UIP]);

    // R7: status B never holds the periodic enable and a PIE write is refused
    p_stb_pie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_q[SB_PIE]);
    p_stb_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_port && req_bytes == 3'd1 &&
         idx_q == 7'h0B && req_wdata[SB_PIE]) |=> (rsp_err && $stable(stb_q)));

    // R8: status D reads power-valid
    p_std_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_port && req_bytes == 3'd1 &&
         idx_q == 7'h0D) |=> rsp_rdata == 8'h80);

endmodule

// File: tb/tb_rtc_regfile.sv
// Bench: behavioural reference model with integers and arrays. Every clock
// is driven through a task that compares the response of the previous cycle.
module tb_rtc_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_port = 1'b0;
    logic [2:0] req_bytes = 3'd1;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid, rsp_err;
    logic [7:0] rsp_rdata;
    logic       sec_tick = 1'b0;
    logic [5:0] tod_sec = 6'd30, tod_min = 6'd45;
    logic [4:0] tod_hour = 5'd13, tod_mday = 5'd9;
    logic [2:0] tod_wday = 3'd2;
    logic [3:0] tod_mon = 4'd5;
    logic [6:0] tod_year = 7'd24, tod_cent = 7'd20;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int m_idx, m_sa, m_sb, m_pend;
    int m_al [3];
    int m_nv [128];
    int s_sec, s_min, s_hour, s_wday, s_mday, s_mon, s_year;

    always #5 clk = ~clk;

    rtc_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_port(req_port),
        .req_bytes(req_bytes), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .sec_tick(sec_tick), .tod_sec(tod_sec), .tod_min(tod_min),
        .tod_hour(tod_hour), .tod_wday(tod_wday), .tod_mday(tod_mday),
        .tod_mon(tod_mon), .tod_year(tod_year), .tod_cent(tod_cent)
    );

    function automatic int bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int mfmt(int v);
        return (m_sb & 4) ? v : bcd(v);
    endfunction

    function automatic int mread(int i);
        int h;
        case (i)
            0: return mfmt(s_sec);
            2: return mfmt(s_min);
            4: begin
                if (m_sb & 2) return mfmt(s_hour);
                h = s_hour % 12;
                if (h == 0) h = 12;
                return mfmt(h) | ((s_hour >= 12) ? 8'h80 : 0);
            end
            6: return mfmt(s_wday + 1);
            7: return mfmt(s_mday);
            8: return mfmt(s_mon + 1);
            9: return mfmt(s_year);
            1, 3, 5: return m_al[i / 2];
            10: return m_sa;
            11: return m_sb;
            12: return 0;
            13: return 8'h80;
            default: return m_nv[i];
        endcase
    endfunction

    task automatic compare(bit ev, bit ee, int ed, string rq);
        total++;
        if (rsp_valid !== ev || rsp_err !== ee || rsp_rdata !== 8'(ed)) begin
            bad++;
            $display("FAIL %s: got v=%0b e=%0b d=%02h, expected v=%0b e=%0b d=%02h",
                     rq, rsp_valid, rsp_err, rsp_rdata, ev, ee, 8'(ed));
        end
    endtask

    // One idle cycle, optionally with a tick; checks the bus stays quiet
    task automatic idle(bit tick, string rq);
        req_valid = 1'b0;
        sec_tick  = tick;
        @(negedge clk);
        sec_tick  = 1'b0;
        if (tick) m_pend = 1;
        compare(1'b0, 1'b0, 0, rq);
    endtask

    // One access; the model decides the response, checked a cycle later
    task automatic acc(bit w, bit port, int bytes, int data, string rq);
        bit ee = 0;
        int ed = 0;
        req_valid = 1'b1; req_write = w; req_port = port;
        req_bytes = 3'(bytes); req_wdata = 8'(data);
        if (bytes != 1) ee = 1;
        else if (!port) begin
            if (w) m_idx = data & 8'h7F; else ed = 8'hFF;
        end else begin
            if (m_pend != 0 && (m_sb & 8'h80) == 0) begin
                s_sec = tod_sec; s_min = tod_min; s_hour = tod_hour;
                s_wday = tod_wday; s_mday = tod_mday; s_mon = tod_mon;
                s_year = tod_year; m_pend = 0;
            end
            if (w) begin
                case (m_idx)
                    10: m_sa = data & 8'h7F;
                    11: if (data & 8'h40) ee = 1; else m_sb = data;
                    12: ee = 1;
                    1, 3, 5: m_al[m_idx / 2] = data;
                    default: if (m_idx >= 14) m_nv[m_idx] = data;
                endcase
            end else ed = mread(m_idx);
        end
        @(negedge clk);
        req_valid = 1'b0;
        compare(1'b1, ee, ed, rq);
    endtask

    task automatic rd(int i, string rq);
        acc(1, 0, 1, i, rq);
        acc(0, 1, 1, 0, rq);
    endtask

    task automatic wr(int i, int v, string rq);
        acc(1, 0, 1, i, rq);
        acc(1, 1, 1, v, rq);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_idx = 0; m_sa = 0; m_sb = 0; m_pend = 1;
        s_sec = 0; s_min = 0; s_hour = 0; s_wday = 0; s_mday = 0; s_mon = 0; s_year = 0;
        for (int i = 0; i < 3; i++) m_al[i] = 0;
        for (int i = 0; i < 128; i++) m_nv[i] = 0;
        m_nv[8'h32] = bcd(20);
        repeat (3) @(negedge clk);
        compare(1'b0, 1'b0, 0, "R3 reset quiet");
        rst_n = 1'b1;
        idle(0, "R3 idle");

        // reset state
        rd(8'h0A, "R6 reset A");  rd(8'h0B, "R7 reset B");
        rd(8'h03, "R10 reset alarm"); rd(8'h32, "R11 century");
        rd(8'h40, "R11 cleared");

        // first refresh and BCD, 12-hour formatting
        rd(8'h00, "R4 first refresh");
        tod_sec = 6'd31;
        rd(8'h00, "R4 no tick keeps old");
        idle(1, "R4 tick");
        rd(8'h00, "R4 tick refresh");
        rd(8'h04, "R12 hour 12h bcd pm");
        rd(8'h06, "R12 weekday"); rd(8'h08, "R12 month");
        rd(8'h09, "R12 year");    rd(8'h07, "R12 mday");
        wr(8'h0B, 8'h04, "R7 bin 12h");
        rd(8'h04, "R12 hour 12h bin");
        wr(8'h0B, 8'h06, "R7 bin 24h");
        rd(8'h04, "R12 hour 24h bin");
        rd(8'h02, "R12 minutes bin");
        wr(8'h0B, 8'h02, "R7 bcd 24h");
        tod_hour = 5'd23; idle(1, "R4 tick");
        rd(8'h04, "R12 hour 24h bcd");
        tod_hour = 5'd0; idle(1, "R4 tick");
        wr(8'h0B, 8'h00, "R7 12h");
        rd(8'h04, "R12 midnight");

        // status B rules and halt
        wr(8'h0B, 8'h46, "R7 PIE reject");
        rd(8'h0B, "R7 unchanged");
        wr(8'h0B, 8'h86, "R5 set halt");
        tod_sec = 6'd50; idle(1, "R5 tick under halt");
        rd(8'h00, "R5 frozen");
        wr(8'h0B, 8'h06, "R5 clear halt");
        rd(8'h00, "R5 refresh after halt");

        // status A, C, D
        wr(8'h0A, 8'hFF, "R6 write A");
        rd(8'h0A, "R6 UIP masked");
        wr(8'h0C, 8'h12, "R8 C write reject");
        rd(8'h0C, "R8 C zero");
        wr(8'h0D, 8'h00, "R8 D write ignored");
        rd(8'h0D, "R8 D power");

        // time writes ignored, alarms raw
        wr(8'h00, 8'h55, "R9 write sec");
        rd(8'h00, "R9 sec unchanged");
        wr(8'h09, 8'h01, "R9 write year");
        rd(8'h09, "R9 year unchanged");
        wr(8'h01, 8'hA5, "R10 alarm s");
        wr(8'h03, 8'h7E, "R10 alarm m");
        wr(8'h05, 8'hFF, "R10 alarm h");
        rd(8'h01, "R10 raw s"); rd(8'h03, "R10 raw m"); rd(8'h05, "R10 raw h");

        // byte store edges
        wr(8'h0E, 8'h11, "R11 low"); wr(8'h7F, 8'hEE, "R11 high");
        rd(8'h0E, "R11 low"); rd(8'h7F, "R11 high"); rd(8'h32, "R11 century kept");

        // index port behaviour and size rejection
        acc(0, 0, 1, 0, "R2 index read");
        acc(1, 0, 1, 8'h8E, "R2 bit7 ignored");
        acc(0, 1, 1, 0, "R2 selects 0x0E");
        acc(1, 0, 2, 8'h0A, "R1 bad size index");
        acc(0, 1, 1, 0, "R1 index kept");
        acc(1, 1, 4, 8'h99, "R1 bad size data");
        acc(0, 1, 1, 0, "R1 store kept");
        acc(0, 0, 0, 0, "R1 zero size");
        idle(0, "R3 quiet after");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule